// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank Tracker

This block is the control front end of a behavioural double-data-rate SDRAM device model. On every rising clock edge it samples the clock enable, the four active-low command pins, the bank-address bits and the address bus. It decodes the command and keeps a per-bank record of which banks hold an open row and which row that is. It also holds the device's power state and stores the two mode-register op-codes. A memory-array or data-path model built beside it uses its strobes and state to find out which row, and which configuration, an access refers to.

Every output except the power state is registered. Command strobes and flags are therefore high for the one clock cycle that follows the edge at which the command was sampled. A command that breaks the bank rules raises an error flag instead of its strobe and leaves all stored state unchanged. The power state is also registered, with one exception: the output leaves self refresh as soon as the clock enable rises, without waiting for a clock edge.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: Inputs are sampled on the rising clock edge. The command is coded active-low on {cs_n, ras_n, cas_n, we_n}: 0111 NOP, 0011 Activate, 0101 Read, 0100 Write, 0010 Precharge, 0001 Refresh, 0000 Mode register set. Each accepted command pulses its strobe for exactly the one cycle after the sampling edge, and the strobes are never high together.
- R2: When cs_n is sampled high, the command is a NOP whatever ras_n, cas_n and we_n hold. No strobe and no flag fires, and no state changes.
- R3: An Activate to an idle bank, selected by ba, marks that bank open and stores addr as its open row, which appears in open_rows_o bits [b*13 +: 13].
- R4: A Read or Write to an open bank pulses its strobe. The bank stays open when addr[10] is 0 and becomes idle when addr[10] is 1 (auto-precharge).
- R5: Precharge with addr[10]=0 closes only bank ba. With addr[10]=1 it closes every bank and ba is ignored. Precharging an idle bank is legal.
- R6: Mode register set with ba=0 stores addr in mode_reg_o, and with ba=1 stores it in ext_mode_reg_o. With ba=2 or ba=3 it is illegal. A Refresh with all banks idle pulses ref_o.
- R7: The illegal flag is raised instead of a strobe for four cases: a Read or Write to an idle bank, an Activate to an open bank, a Refresh while any bank is open, and a Mode register set while any bank is open. An illegal command changes neither bank state, open rows nor the mode registers.
- R8: When CKE is sampled low in the normal state with no access window running, the block enters precharge power-down (pwr_state_o=1) if all banks are idle and active power-down (pwr_state_o=2) otherwise. The next edge with CKE high returns it to normal (0). Commands are ignored while CKE is low and while the block is not in the normal state.
- R9: A Refresh sampled with CKE low and all banks idle enters self refresh (pwr_state_o=3). pwr_state_o shows normal as soon as CKE goes high, before any clock edge. The same command with a bank open raises the illegal flag and stays in the normal state.
- R10: For ACCESS_CYC (default 4) edges after an accepted Read or Write, CKE sampled low pulses cke_err_o and the power state stays normal.
- R11: Asynchronous reset (rst_n low) clears all banks, rows, mode registers, strobes and flags, and sets the power state to normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin, active low |
| cas_n | input | 1 | Column strobe command pin, active low |
| we_n | input | 1 | Write-enable command pin, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column/auto-precharge or op-code |
| act_o | output | 1 | Activate accepted |
| rd_o | output | 1 | Read accepted |
| wr_o | output | 1 | Write accepted |
| pre_o | output | 1 | Precharge accepted |
| ref_o | output | 1 | Refresh accepted |
| mrs_o | output | 1 | Mode register set accepted |
| illegal_o | output | 1 | Command broke the bank rules |
| cke_err_o | output | 1 | CKE low during an access window |
| bank_open_o | output | 4 | One bit per bank, 1 = row open |
| open_rows_o | output | 52 | Open row of each bank, 13 bits per bank |
| mode_reg_o | output | 13 | Mode register op-code |
| ext_mode_reg_o | output | 13 | Extended mode register op-code |
| pwr_state_o | output | 2 | 0 normal, 1 precharge PD, 2 active PD, 3 self refresh |

## Verification
A table of commands drives the decoder through each command code, issued both to idle and to open banks, so that legal and illegal outcomes of the same code are told apart. The table also includes a masked chip select that carries an Activate pattern, and precharges with addr[10] low and high, which separate single-bank from all-bank closing. Directed sequences then take CKE low in three situations: with all banks idle, with a bank open, and together with a Refresh. These sequences separate the three entry states from the illegal self-refresh case. Taking CKE low on the first and on the last edge of the access window, and again one edge later, fixes the window boundary. Raising CKE between clock edges during self refresh checks that the exit does not wait for an edge.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS,
    CMD_OTHER
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_NORMAL = 2'd0,
    PWR_PPD    = 2'd1,
    PWR_APD    = 2'd2,
    PWR_SELF   = 2'd3
  } pwr_e;

  // strobe vector bit positions
  localparam int STB_MRS  = 0;
  localparam int STB_REF  = 1;
  localparam int STB_PRE  = 2;
  localparam int STB_WR   = 3;
  localparam int STB_RD   = 4;
  localparam int STB_ACT  = 5;
  localparam int STB_ILL  = 6;
  localparam int STB_CKE  = 7;
  localparam int STB_W    = 8;

endpackage

// File: rtl/ddr_trk_decode.sv
module ddr_trk_decode
  import ddr_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  // R1 command coding, R2 chip-select masking
  always_comb begin
    cmd = CMD_NOP;
    if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/ddr_trk_bank.sv
module ddr_trk_bank #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_set,
  input  logic             close,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q
);

  logic             open_d;
  logic [ROW_W-1:0] row_d;

  always_comb begin
    open_d = open_q;
    row_d  = row_q;
    if (open_set) begin
      open_d = 1'b1;
      row_d  = row_in;
    end else if (close) begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else begin
      open_q <= open_d;
      row_q  <= row_d;
    end
  end

  // R3: an activate opens the bank and captures the row
  p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    open_set |=> (open_q && row_q == $past(row_in)));

  // R5: a close request leaves the bank idle
  p_close_idles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (close && !open_set) |=> !open_q);

endmodule

// File: rtl/ddr_trk_power.sv
module ddr_trk_power
  import ddr_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic is_ref,
  input  logic any_open,
  input  logic busy,
  output pwr_e state_q,
  output pwr_e state_vis,
  output logic cmd_en,
  output logic cke_err,
  output logic sr_bad
);

  pwr_e state_d;

  // R8, R9, R10 power state transitions
  always_comb begin
    state_d = state_q;
    cke_err = 1'b0;
    sr_bad  = 1'b0;
    unique case (state_q)
      PWR_NORMAL: begin
        if (!cke) begin
          if (busy) begin
            cke_err = 1'b1;
          end else if (is_ref && any_open) begin
            sr_bad = 1'b1;
          end else if (is_ref) begin
            state_d = PWR_SELF;
          end else if (any_open) begin
            state_d = PWR_APD;
          end else begin
            state_d = PWR_PPD;
          end
        end
      end
      default: begin
        if (cke) state_d = PWR_NORMAL;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_NORMAL;
    else        state_q <= state_d;
  end

  // R9: self-refresh exit is visible without a clock edge
  assign state_vis = (state_q == PWR_SELF && cke) ? PWR_NORMAL : state_q;
  assign cmd_en    = (state_q == PWR_NORMAL) && cke;

  // R8: active power-down only with a row open, precharge power-down only idle
  p_apd_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PWR_APD) |-> any_open);
  p_ppd_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PWR_PPD) |-> !any_open);

  // R9: self refresh holds only with every bank idle, leaves on CKE high
  p_sr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PWR_SELF) |-> !any_open);
  p_sr_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PWR_SELF && cke) |=> (state_q == PWR_NORMAL));

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_trk_pkg::*;
#(
  parameter int BA_W       = 2,
  parameter int ADDR_W     = 13,
  parameter int AP_BIT     = 10,
  parameter int ACCESS_CYC = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cke,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [BA_W-1:0]               ba,
  input  logic [ADDR_W-1:0]             addr,
  output logic                          act_o,
  output logic                          rd_o,
  output logic                          wr_o,
  output logic                          pre_o,
  output logic                          ref_o,
  output logic                          mrs_o,
  output logic                          illegal_o,
  output logic                          cke_err_o,
  output logic [(1<<BA_W)-1:0]          bank_open_o,
  output logic [(1<<BA_W)*ADDR_W-1:0]   open_rows_o,
  output logic [ADDR_W-1:0]             mode_reg_o,
  output logic [ADDR_W-1:0]             ext_mode_reg_o,
  output logic [1:0]                    pwr_state_o
);

  localparam int NUM_BANKS = 1 << BA_W;
  localparam int CNT_W     = $clog2(ACCESS_CYC + 1);

  cmd_e cmd;
  pwr_e pwr_q;
  pwr_e pwr_vis;
  logic cmd_en;
  logic pd_cke_err;
  logic pd_sr_bad;

  logic [NUM_BANKS-1:0] open_q;
  logic [NUM_BANKS-1:0] act_set;
  logic [NUM_BANKS-1:0] close_req;
  logic                 sel_open;
  logic                 any_open;
  logic                 ap_bit;
  logic                 ba_hi;
  logic                 ill_cmd;
  logic                 legal;

  logic [CNT_W-1:0]  win_q, win_d;
  logic              busy;

  logic [STB_W-1:0]  stb_q, stb_d;
  logic [ADDR_W-1:0] mr_q, mr_d, emr_q, emr_d;
  logic              mr_en, emr_en;

  ddr_trk_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  assign sel_open = open_q[ba];
  assign any_open = |open_q;
  assign ap_bit   = addr[AP_BIT];
  assign ba_hi    = (ba >> 1) != '0;
  assign busy     = (win_q != '0);

  ddr_trk_power u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .is_ref    (cmd == CMD_REF),
    .any_open  (any_open),
    .busy      (busy),
    .state_q   (pwr_q),
    .state_vis (pwr_vis),
    .cmd_en    (cmd_en),
    .cke_err   (pd_cke_err),
    .sr_bad    (pd_sr_bad)
  );

  // R7: bank-rule check
  always_comb begin
    ill_cmd = 1'b0;
    unique case (cmd)
      CMD_ACT:         ill_cmd = sel_open;
      CMD_RD, CMD_WR:  ill_cmd = !sel_open;
      CMD_REF:         ill_cmd = any_open;
      CMD_MRS:         ill_cmd = any_open || ba_hi;
      default:         ill_cmd = 1'b0;
    endcase
  end

  assign legal = cmd_en && !ill_cmd;

  // R3, R4, R5: per-bank open and close requests
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      act_set[b]   = legal && (cmd == CMD_ACT) && (ba == BA_W'(b));
      close_req[b] = legal &&
                     (((cmd == CMD_PRE) && (ap_bit || ba == BA_W'(b))) ||
                      ((cmd == CMD_RD || cmd == CMD_WR) && ap_bit && ba == BA_W'(b)));
    end
  end

  generate
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      ddr_trk_bank #(.ROW_W(ADDR_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_set (act_set[g]),
        .close    (close_req[g]),
        .row_in   (addr),
        .open_q   (open_q[g]),
        .row_q    (open_rows_o[g*ADDR_W +: ADDR_W])
      );
    end
  endgenerate

  // R10: access window after each accepted read or write
  always_comb begin
    win_d = win_q;
    if (legal && (cmd == CMD_RD || cmd == CMD_WR)) win_d = CNT_W'(ACCESS_CYC);
    else if (busy)                                 win_d = win_q - 1'b1;
  end

  // R6: mode register capture
  assign mr_en  = legal && (cmd == CMD_MRS) && (ba == BA_W'(0));
  assign emr_en = legal && (cmd == CMD_MRS) && (ba == BA_W'(1));
  assign mr_d   = mr_en  ? addr : mr_q;
  assign emr_d  = emr_en ? addr : emr_q;

  // R1: one-cycle strobes
  always_comb begin
    stb_d          = '0;
    stb_d[STB_ACT] = legal && (cmd == CMD_ACT);
    stb_d[STB_RD]  = legal && (cmd == CMD_RD);
    stb_d[STB_WR]  = legal && (cmd == CMD_WR);
    stb_d[STB_PRE] = legal && (cmd == CMD_PRE);
    stb_d[STB_REF] = legal && (cmd == CMD_REF);
    stb_d[STB_MRS] = legal && (cmd == CMD_MRS);
    stb_d[STB_ILL] = (cmd_en && ill_cmd) || pd_sr_bad;
    stb_d[STB_CKE] = pd_cke_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      stb_q <= '0;
      mr_q  <= '0;
      emr_q <= '0;
    end else begin
      win_q <= win_d;
      stb_q <= stb_d;
      mr_q  <= mr_d;
      emr_q <= emr_d;
    end
  end

  assign act_o          = stb_q[STB_ACT];
  assign rd_o           = stb_q[STB_RD];
  assign wr_o           = stb_q[STB_WR];
  assign pre_o          = stb_q[STB_PRE];
  assign ref_o          = stb_q[STB_REF];
  assign mrs_o          = stb_q[STB_MRS];
  assign illegal_o      = stb_q[STB_ILL];
  assign cke_err_o      = stb_q[STB_CKE];
  assign bank_open_o    = open_q;
  assign mode_reg_o     = mr_q;
  assign ext_mode_reg_o = emr_q;
  assign pwr_state_o    = pwr_vis;

  // R1: at most one strobe or flag per cycle
  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_q));

  // R2: a deselected cycle produces no strobe and no bank-rule flag
  p_cs_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !(act_o || rd_o || wr_o || pre_o || ref_o || mrs_o || illegal_o));

  // R7: illegal commands leave banks and mode registers untouched
  p_ill_banks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (bank_open_o == $past(bank_open_o)));
  p_ill_modes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> ($stable(mode_reg_o) && $stable(ext_mode_reg_o)));

  // R10: access window never longer than ACCESS_CYC
  p_window_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= CNT_W'(ACCESS_CYC));

endmodule

// File: tb/ddr_cmd_tracker_tb.sv
module ddr_cmd_tracker_tb;

  logic        clk;
  logic        rst_n;
  logic        cke;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic        act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, illegal_o, cke_err_o;
  logic [3:0]  bank_open_o;
  logic [51:0] open_rows_o;
  logic [12:0] mode_reg_o, ext_mode_reg_o;
  logic [1:0]  pwr_state_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;

  ddr_cmd_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .ref_o(ref_o),
    .mrs_o(mrs_o), .illegal_o(illegal_o), .cke_err_o(cke_err_o),
    .bank_open_o(bank_open_o), .open_rows_o(open_rows_o),
    .mode_reg_o(mode_reg_o), .ext_mode_reg_o(ext_mode_reg_o),
    .pwr_state_o(pwr_state_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: cke, cmd, ba, addr | exp open, exp {ill,act,rd,wr,pre,ref,mrs}, exp pwr
  localparam int NV = 19;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {1'b1, 4'b0111, 2'd0, 13'h0000, 4'b0000, 7'b0000000, 2'd0}, // NOP
    {1'b1, 4'b0011, 2'd0, 13'h0123, 4'b0001, 7'b0100000, 2'd0}, // ACT b0
    {1'b1, 4'b0011, 2'd2, 13'h1ABC, 4'b0101, 7'b0100000, 2'd0}, // ACT b2
    {1'b1, 4'b0011, 2'd0, 13'h0555, 4'b0101, 7'b1000000, 2'd0}, // ACT open b0
    {1'b1, 4'b0101, 2'd1, 13'h0010, 4'b0101, 7'b1000000, 2'd0}, // RD idle b1
    {1'b1, 4'b0101, 2'd0, 13'h0010, 4'b0101, 7'b0010000, 2'd0}, // RD b0
    {1'b1, 4'b1011, 2'd1, 13'h0077, 4'b0101, 7'b0000000, 2'd0}, // masked ACT
    {1'b1, 4'b0100, 2'd2, 13'h0400, 4'b0001, 7'b0001000, 2'd0}, // WR b2 auto-pre
    {1'b1, 4'b0010, 2'd0, 13'h0000, 4'b0000, 7'b0000100, 2'd0}, // PRE b0
    {1'b1, 4'b0001, 2'd0, 13'h0000, 4'b0000, 7'b0000010, 2'd0}, // REF
    {1'b1, 4'b0000, 2'd0, 13'h0032, 4'b0000, 7'b0000001, 2'd0}, // MRS
    {1'b1, 4'b0000, 2'd1, 13'h0005, 4'b0000, 7'b0000001, 2'd0}, // EMRS
    {1'b1, 4'b0000, 2'd2, 13'h0099, 4'b0000, 7'b1000000, 2'd0}, // MRS ba2
    {1'b1, 4'b0011, 2'd3, 13'h1FFF, 4'b1000, 7'b0100000, 2'd0}, // ACT b3
    {1'b1, 4'b0011, 2'd1, 13'h0001, 4'b1010, 7'b0100000, 2'd0}, // ACT b1
    {1'b1, 4'b0001, 2'd0, 13'h0000, 4'b1010, 7'b1000000, 2'd0}, // REF open
    {1'b1, 4'b0000, 2'd0, 13'h0777, 4'b1010, 7'b1000000, 2'd0}, // MRS open
    {1'b1, 4'b0010, 2'd0, 13'h0400, 4'b0000, 7'b0000100, 2'd0}, // PRE all
    {1'b1, 4'b0010, 2'd1, 13'h0000, 4'b0000, 7'b0000100, 2'd0}  // PRE idle b1
  };
  localparam string VTAG [0:NV-1] = '{
    "R1", "R3", "R3", "R7", "R7", "R4", "R2", "R4", "R5", "R6",
    "R6", "R6", "R6", "R3", "R3", "R7", "R7", "R5", "R5"
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic k, input logic [3:0] c, input logic [1:0] b,
                       input logic [12:0] a);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [6:0] stb7();
    return {illegal_o, act_o, rd_o, wr_o, pre_o, ref_o, mrs_o};
  endfunction

  initial begin
    rst_n = 1'b0;
    cke = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    ba = '0;
    addr = '0;
    #20;
    // R11: reset state
    check("R11 open", 64'(bank_open_o), 64'h0);
    check("R11 pwr", 64'(pwr_state_o), 64'h0);
    check("R11 stb", 64'({stb7(), cke_err_o}), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][32], VEC[i][31:28], VEC[i][27:26], VEC[i][25:13]);
      check({VTAG[i], " open"}, 64'(bank_open_o), 64'(VEC[i][12:9]));
      check({VTAG[i], " strobes"}, 64'(stb7()), 64'(VEC[i][8:2]));
      check({VTAG[i], " pwr"}, 64'(pwr_state_o), 64'(VEC[i][1:0]));
    end
    // R7: illegal ACT kept row 0x0123, illegal MRS kept 0x0032
    check("R7 row0", 64'(open_rows_o[12:0]), 64'h0123);
    check("R3 row3", 64'(open_rows_o[51:39]), 64'h1FFF);
    check("R7 mode", 64'(mode_reg_o), 64'h0032);
    check("R6 ext mode", 64'(ext_mode_reg_o), 64'h0005);

    // R8: precharge power-down, commands ignored, exit
    apply(1'b0, C_NOP, 2'd0, 13'h0);
    check("R8 ppd", 64'(pwr_state_o), 64'd1);
    apply(1'b0, C_ACT, 2'd1, 13'h0AAA);
    check("R8 ignored act open", 64'(bank_open_o), 64'h0);
    check("R8 ignored act strobe", 64'(stb7()), 64'h0);
    apply(1'b1, C_NOP, 2'd0, 13'h0);
    check("R8 ppd exit", 64'(pwr_state_o), 64'd0);

    // R8: active power-down
    apply(1'b1, C_ACT, 2'd1, 13'h0AAA);
    apply(1'b0, C_NOP, 2'd0, 13'h0);
    check("R8 apd", 64'(pwr_state_o), 64'd2);
    apply(1'b0, C_PRE, 2'd1, 13'h0400);
    check("R8 ignored pre", 64'(bank_open_o), 64'b0010);
    apply(1'b1, C_NOP, 2'd0, 13'h0);
    check("R8 apd exit", 64'(pwr_state_o), 64'd0);

    // R9: self-refresh request with an open bank
    apply(1'b0, C_REF, 2'd0, 13'h0);
    check("R9 sr open illegal", 64'(illegal_o), 64'd1);
    check("R9 sr open stays", 64'(pwr_state_o), 64'd0);
    apply(1'b1, C_PRE, 2'd1, 13'h0);
    check("R5 pre b1", 64'(bank_open_o), 64'h0);

    // R9: self refresh entry and asynchronous exit
    apply(1'b0, C_REF, 2'd0, 13'h0);
    check("R9 sr entry", 64'(pwr_state_o), 64'd3);
    check("R9 sr no flag", 64'(illegal_o), 64'd0);
    #1 cke = 1'b1;
    #1 check("R9 async exit", 64'(pwr_state_o), 64'd0);
    apply(1'b1, C_NOP, 2'd0, 13'h0);
    check("R9 exit held", 64'(pwr_state_o), 64'd0);

    // R10: access window first and last edge, then one past it
    apply(1'b1, C_ACT, 2'd0, 13'h0042);
    apply(1'b1, C_RD, 2'd0, 13'h0008);
    check("R4 rd keeps open", 64'(bank_open_o), 64'b0001);
    apply(1'b0, C_NOP, 2'd0, 13'h0);
    check("R10 err first", 64'(cke_err_o), 64'd1);
    check("R10 stay normal", 64'(pwr_state_o), 64'd0);
    apply(1'b1, C_NOP, 2'd0, 13'h0);
    apply(1'b1, C_NOP, 2'd0, 13'h0);
    apply(1'b0, C_NOP, 2'd0, 13'h0);
    check("R10 err last", 64'(cke_err_o), 64'd1);
    apply(1'b0, C_NOP, 2'd0, 13'h0);
    check("R10 window over", 64'(cke_err_o), 64'd0);
    check("R8 apd after window", 64'(pwr_state_o), 64'd2);
    apply(1'b1, C_NOP, 2'd0, 13'h0);

    // R11: asynchronous reset mid-run
    #1 rst_n = 1'b0;
    #1;
    check("R11 async open", 64'(bank_open_o), 64'h0);
    check("R11 async mode", 64'(mode_reg_o), 64'h0);
    check("R11 async pwr", 64'(pwr_state_o), 64'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule